// File: doc/BRIEF.md
# Timestamp Timer with Selectable Timebase

This block keeps a free-running timestamp count that software reads to tag events with a time value. It runs from a 50 MHz system clock and derives three timebases from it: nanoseconds, where each 20 ns clock cycle adds 20 to the count; microseconds, where the count advances once every 50 cycles; and milliseconds, where it advances once every 50000 cycles. A configuration register selects the timebase and holds a zero-hold control bit.

Software zeroes the count in two writes. The first write sets the hold bit together with the wanted source, and the second write clears the hold bit and gives the same source. A source value outside the three legal codes is dropped whole. Moving to a new source restarts the internal prescaler but leaves the count where it is. The count wraps around modulo 2^COUNT_W without stopping. COUNT_W defaults to 32.

Top module: `ts_timer`

## Requirements
- R1: Out of reset the source is 0 (nanoseconds), the hold bit is clear, and the count reads 0 for as long as rst_n is low.
- R2: With reg_sel=0, reg_rdata returns the source code in bits 7:0, the hold bit in bit 8 and zeros above it. With reg_sel=1 it returns the count, zero-extended to 32 bits. A write with reg_we=1 and reg_sel=0 updates the configuration.
- R3: A configuration write with bit 8 set and a legal source makes the count read 0 from the second clock edge after the write edge. The count stays 0 while the bit remains set.
- R4: A write that clears bit 8 lets counting resume from 0. The source written alongside the hold bit is kept across the hold pulse.
- R5: With source 0 the count grows by 20 on every clock edge while the hold bit is clear.
- R6: With source 1 the count grows by 1 every 50 cycles. The first step comes 50 edges after the hold release or source change takes effect.
- R7: With source 2 the count grows by 1 every 50000 cycles, counted from the edge where the source change is written.
- R8: A configuration write whose bits 7:0 exceed 2 is ignored entirely. Source, hold bit, prescaler phase and count carry on as if the write had not happened.
- R9: Writing a different legal source restarts the prescaler on the write edge and does not clear the count.
- R10: The count wraps modulo 2^COUNT_W and keeps counting. In the nanosecond timebase it wraps from the last multiple of 20 below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 configuration, 1 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |

## Verification
The count is tried in each of the three timebases. The nanosecond run checks the per-cycle step of 20 and the wrap with a narrowed count, which separates a correct modulo wrap from saturation or a wrong step. The microsecond run samples one cycle before and exactly on each expected step, which exposes an off-by-one in the divider. A switch to the millisecond timebase taken part-way through a microsecond period shows whether the prescaler restarts on the change, because a stale phase would move the first step about twenty cycles earlier. Illegal source writes that carry the hold bit show that the whole write is dropped and not only its source field.

// File: rtl/ts_timer_pkg.sv
// Shared types and field layout for the timestamp timer.
package ts_timer_pkg;
    // Timebase codes; the numeric values are the software-visible source codes.
    typedef enum logic [1:0] {
        TB_NS = 2'd0,
        TB_US = 2'd1,
        TB_MS = 2'd2
    } timebase_e;

    localparam int REG_W       = 32;  // register data width
    localparam int SRC_FIELD_W = 8;   // width of the source field
    localparam int HOLD_BIT    = 8;   // position of the zero-hold bit
    localparam int MAX_SRC     = 2;   // highest legal source code
endpackage

// File: rtl/ts_cfg_reg.sv
// Configuration register: stores the timebase source and the zero-hold bit.
// Assumes a single-cycle write strobe. Writes carrying an illegal source
// code are dropped whole. Flags a restart when a legal write changes the source.
module ts_cfg_reg
    import ts_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output timebase_e        src,
    output logic             hold,
    output logic             restart
);
    timebase_e src_q;
    logic      hold_q;
    logic      src_ok;
    logic      accept;
    timebase_e new_src;

    // Decode the write: legality of the source field and the new code.
    always_comb begin
        src_ok  = (wr_data[SRC_FIELD_W-1:0] <= SRC_FIELD_W'(MAX_SRC));
        new_src = timebase_e'(wr_data[1:0]);
        accept  = wr_en && src_ok;
        restart = accept && (new_src != src_q);
    end

    // Hold the configuration; only legal writes land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= TB_NS;
            hold_q <= 1'b0;
        end else if (accept) begin
            src_q  <= new_src;
            hold_q <= wr_data[HOLD_BIT];
        end
    end

    assign src  = src_q;
    assign hold = hold_q;

    // An illegal source write must leave both fields untouched.
    assert_bad_src_ignored_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !src_ok) |=> ($stable(src_q) && $stable(hold_q)));

    // The stored source never takes the unused code.
    assert_src_legal_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        src_q != timebase_e'(2'd3));
endmodule

// File: rtl/ts_prescaler.sv
// Timebase prescaler: makes a one-cycle tick at the rate of the selected timebase.
// Nanosecond mode ticks every cycle. Microsecond and millisecond modes divide
// by US_DIV and MS_DIV. The phase counter clears while held and on a source change.
module ts_prescaler
    import ts_timer_pkg::*;
#(
    parameter int US_DIV = 50,
    parameter int MS_DIV = 50000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  timebase_e src,
    input  logic      hold,
    input  logic      restart,
    output logic      tick
);
    localparam int MAX_DIV = (MS_DIV > US_DIV) ? MS_DIV : US_DIV;
    localparam int PRE_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    // Pick the terminal phase for the active divider and raise the tick.
    always_comb begin
        limit    = (src == TB_US) ? PRE_W'(US_DIV - 1) : PRE_W'(MS_DIV - 1);
        at_limit = (phase_q == limit);
        unique case (src)
            TB_NS:   tick = !hold;
            TB_US,
            TB_MS:   tick = !hold && at_limit;
            default: tick = 1'b0;
        endcase
    end

    // Advance the phase; clear it when held, restarted or idle in nanosecond mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (hold || restart || (src == TB_NS) || at_limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // No tick may escape while the counter is held at zero.
    assert_quiet_in_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !tick);

    // After a restart in a divided mode the next edge cannot tick.
    assert_restart_no_early_tick_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !hold) |=> ((src == TB_NS) || !tick));
endmodule

// File: rtl/ts_count.sv
// Timestamp count: adds the timebase step on each tick, zero while held.
// Wraps modulo 2^COUNT_W. The step is NS_STEP in nanosecond mode and 1 otherwise.
module ts_count
    import ts_timer_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int NS_STEP = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  timebase_e          src,
    input  logic               hold,
    input  logic               tick,
    output logic [COUNT_W-1:0] count
);
    logic [COUNT_W-1:0] count_q;
    logic [COUNT_W-1:0] step;

    // Step size follows the timebase unit.
    always_comb begin
        step = (src == TB_NS) ? COUNT_W'(NS_STEP) : COUNT_W'(1);
    end

    // Accumulate; the adder carry-out is dropped so the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + step;
        end
    end

    assign count = count_q;

    // Held counter reads zero on the following edge.
    assert_hold_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count_q == '0));

    // Without a tick the count does not move.
    assert_idle_stable_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !tick) |=> $stable(count_q));
endmodule

// File: rtl/ts_timer.sv
// Timestamp timer top: configuration register, prescaler and counter.
// Assumes a 50 MHz clock for the default dividers. Register 0 is the
// configuration and register 1 the read-only count. Reads are combinational.
module ts_timer
    import ts_timer_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int NS_STEP = 20,
    parameter int US_DIV  = 50,
    parameter int MS_DIV  = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    timebase_e          src;
    logic               hold;
    logic               restart;
    logic               tick;
    logic [COUNT_W-1:0] count;
    logic [REG_W-1:0]   count_word;
    logic [REG_W-1:0]   cfg_word;

    ts_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we && !reg_sel),
        .wr_data (reg_wdata),
        .src     (src),
        .hold    (hold),
        .restart (restart)
    );

    ts_prescaler #(.US_DIV(US_DIV), .MS_DIV(MS_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .hold    (hold),
        .restart (restart),
        .tick    (tick)
    );

    ts_count #(.COUNT_W(COUNT_W), .NS_STEP(NS_STEP)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .hold  (hold),
        .tick  (tick),
        .count (count)
    );

    // Zero-extend a narrow count to the register width.
    generate
        if (COUNT_W < REG_W) begin : g_ext
            assign count_word = {{(REG_W-COUNT_W){1'b0}}, count};
        end else begin : g_full
            assign count_word = count[REG_W-1:0];
        end
    endgenerate

    // Build the configuration read word and select the register.
    always_comb begin
        cfg_word              = '0;
        cfg_word[1:0]         = src;
        cfg_word[HOLD_BIT]    = hold;
        reg_rdata             = reg_sel ? count_word : cfg_word;
    end

    // A source change with no tick in flight leaves the count alone.
    assert_change_keeps_count_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !tick && !hold) |=> $stable(count));

    // Configuration read never shows bits beyond the defined fields.
    assert_cfg_clean_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[REG_W-1:HOLD_BIT+1] == '0));
endmodule

// File: tb/ts_timer_test.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares them.
module ts_timer_test;
    localparam int CLK_PERIOD = 20;
    localparam int CW         = 12;      // narrowed count so the wrap is reachable
    localparam int WATCHDOG   = 150000;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    ts_timer #(.COUNT_W(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: select the register and queue the expected read word.
    task automatic chk(input logic sel, input logic [31:0] e, input string t);
        item_t it;
        reg_sel = sel;
        it.tag = t;
        it.exp = e;
        q.push_back(it);
        #2;
    endtask

    // Configuration write landing on the next rising edge; returns at the next falling edge.
    task automatic cfg_wr(input logic [31:0] v);
        reg_we    = 1'b1;
        reg_sel   = 1'b0;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic skip(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pop each expected item and compare against the read port.
    initial begin
        item_t it;
        forever begin
            wait (q.size() != 0);
            #1;
            it = q.pop_front();
            total++;
            if (reg_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s: got %0h expected %0h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("watchdog expired before the sequence ended");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        skip(3);
        chk(1'b1, 32'd0, "R1 count in reset");
        chk(1'b0, 32'd0, "R1 config in reset");
        rst_n = 1'b1;
        skip(1);
        chk(1'b1, 32'd20, "R5 first ns step");

        // Hold pulse with nanosecond source.
        cfg_wr(32'h100);
        chk(1'b1, 32'd40, "R3 hold registered one edge late");
        chk(1'b0, 32'h100, "R2 config shows hold bit");
        skip(1);
        chk(1'b1, 32'd0, "R3 count zero under hold");
        skip(5);
        chk(1'b1, 32'd0, "R3 count stays zero");

        // Release and run in nanoseconds up to the wrap.
        cfg_wr(32'h000);
        chk(1'b1, 32'd0, "R4 zero on release edge");
        chk(1'b0, 32'h000, "R4 config after release");
        skip(1);
        chk(1'b1, 32'd20, "R4 resume from zero");
        skip(3);
        chk(1'b1, 32'd80, "R5 step of 20 per cycle");
        skip(200);
        chk(1'b1, 32'd4080, "R10 last value below wrap");
        skip(1);
        chk(1'b1, 32'd4, "R10 wrap modulo");

        // Microsecond timebase from a fresh zero.
        cfg_wr(32'h101);
        cfg_wr(32'h001);
        chk(1'b1, 32'd0, "R6 zero after hold pulse");
        chk(1'b0, 32'h001, "R6 source is microseconds");
        skip(49);
        chk(1'b1, 32'd0, "R6 no step before 50 cycles");
        skip(1);
        chk(1'b1, 32'd1, "R6 first step at 50 cycles");
        skip(50);
        chk(1'b1, 32'd2, "R6 second step");

        // Illegal source with hold bit must be dropped.
        cfg_wr(32'h103);
        chk(1'b0, 32'h001, "R8 config unchanged");
        skip(49);
        chk(1'b1, 32'd3, "R8 count and phase unaffected");

        // Source change mid-period: phase restarts, count kept.
        skip(20);
        cfg_wr(32'h002);
        chk(1'b1, 32'd3, "R9 count kept on change");
        chk(1'b0, 32'h002, "R9 source is milliseconds");
        skip(49999);
        chk(1'b1, 32'd3, "R9 no early ms step");
        skip(1);
        chk(1'b1, 32'd4, "R7 ms step at 50000 cycles");

        // Hold pulse keeps the millisecond source.
        cfg_wr(32'h102);
        cfg_wr(32'h002);
        chk(1'b1, 32'd0, "R4 zero after pulse");
        chk(1'b0, 32'h002, "R4 source kept across pulse");

        wait (q.size() == 0);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule